// File: doc/BRIEF.md
# Program Memory Write/Erase Controller

This block sequences every access to an on-chip program memory through one 8-bit control/status register. Software writes the register to pick a target space, enable programming and choose the kind of operation. It then sets a start bit. A read fetches one word in a single cycle. A latch load updates one word of a row-sized set of write latches. A row write commits all latches into a row, and a row erase fills a row with all-ones. Writes and erases are self-timed: they run for `OP_CYCLES` clocks, and the start bit stays high until hardware clears it.

The storage is modelled as plain registers. There is a main array of `2**AW` words and a separate configuration space of one row, which holds configuration, user ID and device ID words. An error flag marks any program or erase attempt that has not finished normally, including one cut short by reset. Read data leaves on a valid-only stream: `rd_valid` pulses for one cycle with `rdata`. There is no ready input and no back-pressure, so the consumer must take the word in that cycle.

Register bits: [0] space select (1 = configuration space), [1] program enable, [2] latch-only, [3] erase select, [4] read start, [5] write start, [6] error flag, [7] fixed 1. A word's latch index is `addr[ROW_AW-1:0]` and its row is `addr[AW-1:ROW_AW]`. In the configuration space only `addr[ROW_AW-1:0]` is used.

Top module: `pm_wr_ctrl`

## Requirements
- R1: After reset, bit 7 of `reg_rdata` reads 1, bits 0..5 read 0 and `rd_valid` is 0. Reset does not clear the error flag (bit 6), whose power-up value is unspecified.
- R2: While idle (bits 4 and 5 both 0), a register write loads bits 0..3 and 6. Bits 4 and 5 can only be set by software and are cleared only by hardware. If one write sets both, the read wins and no write starts.
- R3: One clock after the write that sets bit 4, `rd_valid` pulses for one cycle with the addressed word of the selected space on `rdata`. Bit 4 reads 0 again from that same cycle.
- R4: A write start with bit 2 = 1 and bit 3 = 0 loads `wdata` into latch `addr[ROW_AW-1:0]` and leaves the arrays unchanged. Bit 5 clears one clock after it was set.
- R5: A write start with bits 2 and 3 both 0 loads the addressed latch and then programs all latches into the addressed row. Bit 5 reads 1 for exactly `OP_CYCLES+1` clocks after the setting write. When it clears, every latch reads as all-ones.
- R6: A write start with bit 3 = 1 fills the addressed row with all-ones after `OP_CYCLES+1` clocks and clears bit 3 when done. Bit 2 has no effect then: no latch is loaded.
- R7: A write start written with bit 1 = 0 is blocked. Bit 5 stays 0 and neither arrays nor latches change.
- R8: Every write-start attempt sets the error flag. A latch load, row write or row erase that completes normally clears it.
- R9: Bit 0 steers reads, row writes and row erases to the configuration space when 1 and to the main array when 0.
- R10: A reset while a row write or erase is running aborts it. The error flag reads 1, the target row becomes all-ones and the latches become all-ones.
- R11: While bit 5 is 1, register writes are ignored: no field changes and no read starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| addr | input | AW | Word address for read, latch load and row select |
| wdata | input | DW | Word loaded into a write latch |
| rdata | output | DW | Read word, valid with rd_valid |
| rd_valid | output | 1 | One-cycle read data strobe |

## Verification
The hardest case to reach is a reset that arrives in the middle of a self-timed row write. The bench starts a commit, counts a few clocks into the busy window and then pulls reset. It then checks that the error flag survived, reads the whole target row back as all-ones, and commits again to show the latches were emptied. A second hard case is the latch-only bit set together with erase. Random erases set that bit at random, and a later commit exposes any latch the erase wrongly loaded.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int B_SPACE = 0;
  localparam int B_PEN   = 1;
  localparam int B_LONLY = 2;
  localparam int B_ERASE = 3;
  localparam int B_RDGO  = 4;
  localparam int B_WRGO  = 5;
  localparam int B_ERR   = 6;
  localparam int B_FIXED = 7;
endpackage

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg import pm_pkg::*; #(
  parameter int AW        = 8,
  parameter int ROW_AW    = 3,
  parameter int OP_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  input  logic [AW-1:0]     addr,
  output logic [7:0]        reg_rdata,
  output logic              rd_go,
  output logic              space_sel,
  output logic              latch_load,
  output logic              commit,
  output logic              erase,
  output logic              abort,
  output logic [AW-ROW_AW-1:0] op_row,
  output logic              op_space
);
  localparam int CW = $clog2(OP_CYCLES + 1);

  logic          pen, lonly, erase_en, wr_go, err, busy, op_erase;
  logic [CW-1:0] cnt;
  logic          idle, start, go_busy, finish;
  logic          unused_bits;

  assign unused_bits = reg_wdata[B_FIXED];
  assign idle    = !wr_go && !rd_go;
  assign start   = wr_go && !busy;
  assign go_busy = erase_en || !lonly;
  assign finish  = rst_n && busy && (cnt == '0);

  assign latch_load = rst_n && start && !erase_en;
  assign commit     = finish && !op_erase;
  assign erase      = finish && op_erase;
  assign abort      = !rst_n && busy;

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[B_SPACE] = space_sel;
    reg_rdata[B_PEN]   = pen;
    reg_rdata[B_LONLY] = lonly;
    reg_rdata[B_ERASE] = erase_en;
    reg_rdata[B_RDGO]  = rd_go;
    reg_rdata[B_WRGO]  = wr_go;
    reg_rdata[B_ERR]   = err;
    reg_rdata[B_FIXED] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      space_sel <= 1'b0;
      pen       <= 1'b0;
      lonly     <= 1'b0;
      erase_en  <= 1'b0;
      rd_go     <= 1'b0;
      wr_go     <= 1'b0;
      busy      <= 1'b0;
      op_erase  <= 1'b0;
      cnt       <= '0;
      err       <= err | busy;
    end else begin
      if (rd_go) rd_go <= 1'b0;
      if (idle && reg_we) begin
        space_sel <= reg_wdata[B_SPACE];
        pen       <= reg_wdata[B_PEN];
        lonly     <= reg_wdata[B_LONLY];
        erase_en  <= reg_wdata[B_ERASE];
        rd_go     <= reg_wdata[B_RDGO];
        wr_go     <= reg_wdata[B_WRGO] && !reg_wdata[B_RDGO] && reg_wdata[B_PEN];
        err       <= reg_wdata[B_ERR] || (reg_wdata[B_WRGO] && !reg_wdata[B_RDGO]);
      end else if (start) begin
        if (!go_busy) begin
          wr_go <= 1'b0;
          err   <= 1'b0;
        end else begin
          busy     <= 1'b1;
          cnt      <= CW'(OP_CYCLES - 1);
          op_erase <= erase_en;
        end
      end else if (busy) begin
        if (cnt == '0) begin
          busy  <= 1'b0;
          wr_go <= 1'b0;
          err   <= 1'b0;
          if (op_erase) erase_en <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // Target row is kept through reset so an abort can reach it.
  always_ff @(posedge clk) begin
    if (rst_n && start && go_busy) begin
      op_row   <= addr[AW-1:ROW_AW];
      op_space <= space_sel;
    end
  end

  p_rd_go_self_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !rd_go);
  p_start_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_go) |-> pen);
  p_busy_holds_wr_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wr_go);
  p_start_raises_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_go) |-> err);
  p_erase_done_clears_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> !erase_en && !wr_go);
  p_busy_ignores_writes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && reg_we) |=> $stable(space_sel) && $stable(pen) && $stable(lonly) && !rd_go);
endmodule

// File: rtl/pm_write_latches.sv
module pm_write_latches #(
  parameter int DW     = 14,
  parameter int ROW_AW = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [ROW_AW-1:0]            idx,
  input  logic [DW-1:0]                data,
  input  logic                         clear,
  output logic [(1<<ROW_AW)-1:0][DW-1:0] q
);
  localparam int ROW_WORDS = 1 << ROW_AW;

  for (genvar g = 0; g < ROW_WORDS; g++) begin : g_lat
    always_ff @(posedge clk) begin
      if (!rst_n || clear)                    q[g] <= '1;
      else if (load && idx == ROW_AW'(g))     q[g] <= data;
    end
  end

  p_one_latch_per_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> q[$past(idx)] == $past(data));
endmodule

// File: rtl/pm_store.sv
module pm_store #(
  parameter int DW     = 14,
  parameter int AW     = 8,
  parameter int ROW_AW = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_en,
  input  logic                           rd_space,
  input  logic [AW-1:0]                  addr,
  input  logic                           commit,
  input  logic                           erase,
  input  logic                           abort,
  input  logic [AW-ROW_AW-1:0]           row,
  input  logic                           space,
  input  logic [(1<<ROW_AW)-1:0][DW-1:0] lat,
  output logic [DW-1:0]                  rdata,
  output logic                           rd_valid
);
  localparam int ROW_WORDS = 1 << ROW_AW;
  localparam int WORDS     = 1 << AW;

  logic [DW-1:0] main_mem [WORDS];
  logic [DW-1:0] cfg_mem  [ROW_WORDS];

  always_ff @(posedge clk) begin
    if (commit || erase || abort) begin
      for (int i = 0; i < ROW_WORDS; i++) begin
        if (space) cfg_mem[i] <= commit ? lat[i] : '1;
        else       main_mem[{row, ROW_AW'(i)}] <= commit ? lat[i] : '1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= rd_space ? cfg_mem[addr[ROW_AW-1:0]] : main_mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end

  p_valid_follows_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
endmodule

// File: rtl/pm_wr_ctrl.sv
module pm_wr_ctrl #(
  parameter int DW        = 14,
  parameter int AW        = 8,
  parameter int ROW_AW    = 3,
  parameter int OP_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_valid
);
  localparam int RW = AW - ROW_AW;

  logic          rd_go, space_sel, latch_load, commit, erase, abort, op_space;
  logic [RW-1:0] op_row;
  logic [(1<<ROW_AW)-1:0][DW-1:0] lat;

  pm_ctrl_reg #(.AW(AW), .ROW_AW(ROW_AW), .OP_CYCLES(OP_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .addr(addr),
    .reg_rdata(reg_rdata), .rd_go(rd_go), .space_sel(space_sel),
    .latch_load(latch_load), .commit(commit), .erase(erase), .abort(abort),
    .op_row(op_row), .op_space(op_space)
  );

  pm_write_latches #(.DW(DW), .ROW_AW(ROW_AW)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(latch_load), .idx(addr[ROW_AW-1:0]),
    .data(wdata), .clear(commit), .q(lat)
  );

  pm_store #(.DW(DW), .AW(AW), .ROW_AW(ROW_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_go), .rd_space(space_sel), .addr(addr),
    .commit(commit), .erase(erase), .abort(abort), .row(op_row), .space(op_space),
    .lat(lat), .rdata(rdata), .rd_valid(rd_valid)
  );

  p_fixed_bit_r1: assert property (@(posedge clk) reg_rdata[7] == 1'b1);
endmodule

// File: tb/tb_pm_wr_ctrl.sv
module tb_pm_wr_ctrl;
  localparam int DW = 14, AW = 8, ROW_AW = 3, OPC = 16;
  localparam int RW = 1 << ROW_AW;
  localparam logic [7:0] SP = 8'h01, PEN = 8'h02, LO = 8'h04, ER = 8'h08,
                         RDG = 8'h10, WRG = 8'h20, ERRB = 8'h40;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [AW-1:0] addr = 0;
  logic [DW-1:0] wdata = 0, rdata;
  logic rd_valid;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [DW-1:0] mm [1<<AW];
  logic [DW-1:0] cm [RW];
  logic [DW-1:0] ml [RW];

  pm_wr_ctrl dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired: cycles %0d expected below 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_word(input bit sp, input logic [AW-1:0] a);
    return sp ? cm[a[ROW_AW-1:0]] : mm[a];
  endfunction

  function automatic logic [7:0] idle_reg(input logic [7:0] written);
    return 8'h80 | (written & (SP | PEN | LO));
  endfunction

  task automatic reg_write(input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic wait_done(input int exp, input string req);
    int n = 0;
    do begin @(posedge clk); @(negedge clk); n++; end while (reg_rdata[5] && n < 1000);
    chk(n == exp, req, n, exp);
  endtask

  task automatic do_read(input bit sp, input logic [AW-1:0] a, input string req);
    addr = a;
    reg_write(PEN | RDG | (sp ? SP : 8'h00));
    chk(rd_valid == 1'b0, "R3 no early valid", rd_valid, 0);
    @(negedge clk);
    chk(rd_valid && rdata == model_word(sp, a), req, rdata, model_word(sp, a));
    chk(reg_rdata[4] == 1'b0, "R3 read start self clears", reg_rdata[4], 0);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R3 valid is one pulse", rd_valid, 0);
  endtask

  task automatic do_latch(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d;
    reg_write(PEN | LO | WRG);
    chk(reg_rdata[6] == 1'b1, "R8 err set at start", reg_rdata[6], 1);
    wait_done(1, "R4 latch load takes one cycle");
    ml[a[ROW_AW-1:0]] = d;
    chk(reg_rdata == idle_reg(PEN | LO), "R4 R8 register after latch load", reg_rdata, idle_reg(PEN | LO));
  endtask

  task automatic do_write(input bit sp, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [7:0] w;
    w = PEN | WRG | (sp ? SP : 8'h00);
    addr = a; wdata = d;
    reg_write(w);
    wait_done(OPC + 1, "R5 write duration");
    ml[a[ROW_AW-1:0]] = d;
    for (int i = 0; i < RW; i++) begin
      if (sp) cm[i] = ml[i]; else mm[{a[AW-1:ROW_AW], ROW_AW'(i)}] = ml[i];
      ml[i] = '1;
    end
    chk(reg_rdata == idle_reg(w), "R5 R8 register after write", reg_rdata, idle_reg(w));
  endtask

  task automatic do_erase(input bit sp, input logic [AW-1:0] a, input bit lo, input string req);
    logic [7:0] w;
    w = PEN | ER | WRG | (sp ? SP : 8'h00) | (lo ? LO : 8'h00);
    addr = a; wdata = DW'($urandom);
    reg_write(w);
    wait_done(OPC + 1, "R6 erase duration");
    for (int i = 0; i < RW; i++) begin
      if (sp) cm[i] = '1; else mm[{a[AW-1:ROW_AW], ROW_AW'(i)}] = '1;
    end
    chk(reg_rdata == idle_reg(w), req, reg_rdata, idle_reg(w));
  endtask

  task automatic do_blocked(input logic [AW-1:0] a);
    addr = a; wdata = DW'($urandom);
    reg_write(WRG | LO);
    chk(reg_rdata == 8'hC4, "R7 R8 blocked start leaves wr clear, err set", reg_rdata, 8'hC4);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < RW; i++) ml[i] = '1;
    repeat (3) @(negedge clk);
    chk((reg_rdata & ~ERRB) == 8'h80, "R1 reset register", reg_rdata, 8'h80);
    chk(rd_valid == 1'b0, "R1 reset rd_valid", rd_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // Known contents everywhere; erase with latch-only set must not load a latch (R6).
    for (int r = 0; r < (1 << (AW - ROW_AW)); r++)
      do_erase(1'b0, AW'(r << ROW_AW), r[0], "R6 erase clears select, ignores latch-only");
    do_erase(1'b1, '0, 1'b1, "R6 R9 config erase");
    do_read(1'b0, 8'h13, "R3 read erased main word");
    do_read(1'b1, 8'h05, "R9 read erased config word");

    // R2: writing zeros to the start bits does not clear them; idle fields load.
    reg_write(SP | LO | PEN);
    chk(reg_rdata == 8'h87, "R2 fields load while idle", reg_rdata, 8'h87);
    reg_write(PEN | RDG | WRG);
    chk(reg_rdata[5:4] == 2'b01, "R2 read wins over write", reg_rdata[5:4], 1);
    @(negedge clk);

    // R11: writes during a busy row write are ignored.
    addr = 8'h40; wdata = 14'h1A5A;
    reg_write(PEN | WRG);
    repeat (3) @(negedge clk);
    reg_write(SP | LO | ER | RDG | PEN);
    chk(reg_rdata == 8'hE2, "R11 busy ignores register write", reg_rdata, 8'hE2);
    chk(rd_valid == 1'b0, "R11 busy ignores read start", rd_valid, 0);
    wait_done(OPC + 1 - 5, "R5 remaining busy cycles");
    ml[0] = 14'h1A5A;
    for (int i = 0; i < RW; i++) begin mm[8'h40 + i] = ml[i]; ml[i] = '1; end
    do_read(1'b0, 8'h40, "R5 committed word");
    do_read(1'b0, 8'h41, "R5 unloaded latch commits all-ones");

    // Random mix of operations against the bench model.
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [AW-1:0] a;
      op = $urandom_range(0, 9);
      a = AW'($urandom);
      case (op)
        0, 1:    do_read(1'b0, a, "R3 random main read");
        2:       do_read(1'b1, a, "R9 random config read");
        3, 4, 5: do_latch(a, DW'($urandom));
        6:       do_write(1'b0, a, DW'($urandom));
        7:       do_write(1'b1, a, DW'($urandom));
        8:       do_erase($urandom_range(0, 1) == 1, a, $urandom_range(0, 1) == 1, "R6 random erase");
        default: do_blocked(a);
      endcase
    end
    for (int i = 0; i < RW; i++) do_read(1'b1, AW'(i), "R9 config row final contents");

    // R10: reset in the middle of a row write.
    do_latch(8'h93, 14'h0F0F);
    addr = 8'h90; wdata = 14'h2222;
    reg_write(PEN | WRG);
    repeat (4) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(reg_rdata == 8'hC0, "R10 err survives aborting reset", reg_rdata, 8'hC0);
    for (int i = 0; i < RW; i++) begin mm[8'h90 + i] = '1; ml[i] = '1; end
    for (int i = 0; i < RW; i++) do_read(1'b0, AW'(8'h90 + i), "R10 aborted row all-ones");
    do_write(1'b0, 8'hA0, 14'h0777);
    do_read(1'b0, 8'hA3, "R10 latches emptied by aborting reset");
    do_read(1'b0, 8'hA0, "R5 write after abort");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule